// File: doc/BRIEF.md
# ATA PIO Strobe Timing Sequencer

This block produces the pin-level timing of a single programmed-I/O register access on a parallel ATA bus. A host raises a request with a direction, a target device, a chip-select choice, a register address and, for a write, the data word. The block then drives the address and chip selects, waits a setup interval, pulses the active-low read or write strobe, and holds the bus until the full cycle time has run out. After that it reports completion with a one-clock done pulse.

Every interval is a count of the system clock. One 32-bit timing register holds two independent timing sets, one for the master device and one for the slave device. Each access picks its set through its device-select input. The chosen set is captured when the access is accepted, so a later write to the register cannot change an access that is already running. While an access runs, the block raises busy. A request made during that time waits and is never lost.

Top module: `pio_strobe_seq`

## Requirements
- R1: After a synchronous reset the timing register is zero, busy and done are low, both strobes are high, both chip selects are high (2'b11), the address and write data outputs are zero, the write-data enable is low and rd_data is zero.
- R2: The timing register places the master set at bits 13:0 and the slave set at bits 29:16. Within each set, bits 2:0 are setup, bits 7:3 are pulse width and bits 13:8 are cycle time. Bits 31:30 and 15:14 always read as zero, and writes to them are ignored.
- R3: req_dev = 0 selects the master set and req_dev = 1 selects the slave set. The set is captured when the request is accepted, and a register write during the access does not change that access.
- R4: The address and chip selects are valid for max(setup,1) clocks before the strobe falls.
- R5: The strobe stays low for max(pulse,1) clocks. ata_rd_n is used for a read (req_write = 0) and ata_wr_n for a write (req_write = 1), and both use the same setup and pulse values.
- R6: busy is high for exactly max(cycle, S+P+1) clocks, where S and P are the effective setup and pulse counts. done is high for the single clock that follows.
- R7: On a read, rd_data takes the value ata_din had at the clock edge where ata_rd_n returns high. A write leaves rd_data unchanged.
- R8: On a write, ata_dout carries the request data and ata_dout_en is high for every busy clock. Otherwise ata_dout is zero and ata_dout_en is low.
- R9: A request is accepted on the first clock edge at which busy is low. A request held during busy is accepted after the running access ends, and is not dropped.
- R10: During an access ata_addr equals the request address and ata_cs_n is 2'b10 for req_csel = 0 or 2'b01 for req_csel = 1. Both stay stable for the whole access. When idle, ata_addr is zero.
- R11: The two strobes are never low together, and neither is low while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counts are in its periods |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing register |
| cfg_wdata | input | 32 | Timing register write value |
| cfg_rdata | output | 32 | Timing register contents |
| req_valid | input | 1 | Access request, held until accepted |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_dev | input | 1 | 0 = master timing set, 1 = slave timing set |
| req_csel | input | 1 | Chip select to assert (0 or 1) |
| req_addr | input | 3 | Device register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Last captured read data |
| ata_addr | output | 3 | Device address pins |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dout | output | 16 | Data driven toward the device |
| ata_dout_en | output | 1 | Output enable for ata_dout |
| ata_din | input | 16 | Data returned by the device |

## Verification
The embedded assertions check these properties on every clock:
- the two strobes are never low together;
- no strobe falls while the block is idle;
- address and chip selects do not move during an access;
- a strobe is always preceded by a setup phase;
- the elapsed count never passes the cycle target;
- done is a single pulse that accompanies every fall of busy;
- the register holds its value when it is not written.

Some properties can only be shown by the bench's scenarios, which compare every output against a clock-by-clock model:
- the exact lengths of setup, pulse and recovery for zero, mid-range and maximum fields;
- the choice between master and slave fields;
- capture of read data on the right edge;
- the hold-off of a request that arrives during busy;
- immunity to a register write during an access.

// File: rtl/pio_tim_pkg.sv
package pio_tim_pkg;

    localparam int SET_W      = 3;
    localparam int PW_W       = 5;
    localparam int CT_W       = 6;
    localparam int FIELD_W    = SET_W + PW_W + CT_W;
    localparam int SLAVE_OFS  = 16;
    localparam int NUM_DEV    = 2;
    localparam int CFG_W      = 32;
    localparam int CNT_W      = 7;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 3;
    localparam int NUM_CS     = 2;

    // One timing set; packing order mirrors its register bits (LSB = setup)
    typedef struct packed {
        logic [CT_W-1:0]  cycle;
        logic [PW_W-1:0]  pulse;
        logic [SET_W-1:0] setup;
    } tim_set_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOV
    } phase_t;

    // Bits of the register that hold real fields; others are reserved
    function automatic logic [CFG_W-1:0] cfg_keep_mask();
        logic [CFG_W-1:0] m;
        m = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            for (int b = 0; b < FIELD_W; b++) begin
                m[d*SLAVE_OFS + b] = 1'b1;
            end
        end
        return m;
    endfunction

    // A programmed zero still yields one clock
    function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/pio_tim_regfile.sv
module pio_tim_regfile
    import pio_tim_pkg::*;
#(
    parameter int REG_W = CFG_W,
    parameter int NDEV  = NUM_DEV
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [REG_W-1:0]           wdata,
    output logic [REG_W-1:0]           rdata,
    output tim_set_t [NDEV-1:0]        dev_sets
);

    localparam logic [REG_W-1:0] KEEP = REG_W'(cfg_keep_mask());

    logic [REG_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata & KEEP;
        end
    end

    assign rdata = cfg_q;

    for (genvar d = 0; d < NDEV; d++) begin : g_set
        assign dev_sets[d] = tim_set_t'(cfg_q[d*SLAVE_OFS +: FIELD_W]);
    end

    // R2: contents change only through a write
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(we) |-> $stable(cfg_q));

endmodule

// File: rtl/pio_phase_ctrl.sv
module pio_phase_ctrl
    import pio_tim_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  tim_set_t  sel_set,
    output phase_t    phase,
    output logic      done,
    output logic      cap
);

    phase_t        phase_q;
    logic [CW-1:0] ph_q;
    logic [CW-1:0] el_q;
    logic [CW-1:0] s_q, p_q, t_q;
    logic          done_q;

    logic [CW-1:0] s_eff, p_eff, t_min, t_eff, c_raw;

    always_comb begin
        s_eff = floor_one(CW'(sel_set.setup));
        p_eff = floor_one(CW'(sel_set.pulse));
        c_raw = CW'(sel_set.cycle);
        t_min = s_eff + p_eff + CW'(1);
        t_eff = (c_raw > t_min) ? c_raw : t_min;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ph_q    <= '0;
            el_q    <= '0;
            s_q     <= '0;
            p_q     <= '0;
            t_q     <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        s_q     <= s_eff;
                        p_q     <= p_eff;
                        t_q     <= t_eff;
                        ph_q    <= CW'(1);
                        el_q    <= CW'(1);
                        phase_q <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    el_q <= el_q + CW'(1);
                    if (ph_q >= s_q) begin
                        ph_q    <= CW'(1);
                        phase_q <= PH_STROBE;
                    end else begin
                        ph_q <= ph_q + CW'(1);
                    end
                end
                PH_STROBE: begin
                    el_q <= el_q + CW'(1);
                    if (ph_q >= p_q) begin
                        ph_q    <= CW'(1);
                        phase_q <= PH_RECOV;
                    end else begin
                        ph_q <= ph_q + CW'(1);
                    end
                end
                PH_RECOV: begin
                    if (el_q >= t_q) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        el_q <= el_q + CW'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;
    assign done  = done_q;
    assign cap   = (phase_q == PH_STROBE) && (ph_q >= p_q);

    // R4: a strobe phase is always entered from the setup phase
    p_setup_first_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STROBE) && ($past(phase_q) != PH_STROBE)
            |-> $past(phase_q) == PH_SETUP);

    // R6: elapsed count never overruns the captured cycle target
    p_el_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |-> (el_q <= t_q));

    // R6: done only ever accompanies the idle phase
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/pio_bus_drive.sv
module pio_bus_drive
    import pio_tim_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int NCS = NUM_CS,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  phase_t          phase,
    input  logic            cap,
    input  logic            req_write,
    input  logic [CSW-1:0]  req_csel,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW-1:0]   ata_din,
    output logic [AW-1:0]   ata_addr,
    output logic [NCS-1:0]  ata_cs_n,
    output logic            ata_rd_n,
    output logic            ata_wr_n,
    output logic [DW-1:0]   ata_dout,
    output logic            ata_dout_en,
    output logic [DW-1:0]   rd_data
);

    logic           wr_q;
    logic [CSW-1:0] csel_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wd_q;
    logic [DW-1:0]  rd_q;
    logic           active;
    logic           strobing;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= 1'b0;
            csel_q <= '0;
            addr_q <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
        end else begin
            if (start) begin
                wr_q   <= req_write;
                csel_q <= req_csel;
                addr_q <= req_addr;
                wd_q   <= req_wdata;
            end
            if (cap && !wr_q) begin
                rd_q <= ata_din;
            end
        end
    end

    assign active   = (phase != PH_IDLE);
    assign strobing = (phase == PH_STROBE);

    assign ata_rd_n    = !(strobing && !wr_q);
    assign ata_wr_n    = !(strobing && wr_q);
    assign ata_addr    = active ? addr_q : '0;
    assign ata_dout_en = active && wr_q;
    assign ata_dout    = ata_dout_en ? wd_q : '0;
    assign rd_data     = rd_q;

    for (genvar c = 0; c < NCS; c++) begin : g_cs
        assign ata_cs_n[c] = !(active && (csel_q == CSW'(c)));
    end

    // R11: strobes are mutually exclusive
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        ata_rd_n || ata_wr_n);

    // R11 / R8: nothing is driven while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !active |-> (ata_rd_n && ata_wr_n && !ata_dout_en));

    // R10: address and selects hold across consecutive busy clocks
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (rst)
        active && $past(active) |-> ($stable(ata_addr) && $stable(ata_cs_n)));

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_tim_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_dev,
    input  logic               req_csel,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  ata_addr,
    output logic [NUM_CS-1:0]  ata_cs_n,
    output logic               ata_rd_n,
    output logic               ata_wr_n,
    output logic [DATA_W-1:0]  ata_dout,
    output logic               ata_dout_en,
    input  logic [DATA_W-1:0]  ata_din
);

    tim_set_t [NUM_DEV-1:0] dev_sets;
    tim_set_t               sel_set;
    phase_t                 phase;
    logic                   start;
    logic                   cap;

    pio_tim_regfile #(.REG_W(CFG_W), .NDEV(NUM_DEV)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .dev_sets (dev_sets)
    );

    assign sel_set = dev_sets[req_dev];
    assign busy    = (phase != PH_IDLE);
    assign start   = req_valid && !busy;

    pio_phase_ctrl #(.CW(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .sel_set (sel_set),
        .phase   (phase),
        .done    (done),
        .cap     (cap)
    );

    pio_bus_drive #(.DW(DATA_W), .AW(ADDR_W), .NCS(NUM_CS)) u_bus (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .phase       (phase),
        .cap         (cap),
        .req_write   (req_write),
        .req_csel    (req_csel),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .ata_din     (ata_din),
        .ata_addr    (ata_addr),
        .ata_cs_n    (ata_cs_n),
        .ata_rd_n    (ata_rd_n),
        .ata_wr_n    (ata_wr_n),
        .ata_dout    (ata_dout),
        .ata_dout_en (ata_dout_en),
        .rd_data     (rd_data)
    );

    // R6: done is a single-clock pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: busy only ends together with done
    p_busy_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

// File: tb/pio_strobe_seq_tb.sv
`timescale 1ns/1ps
module pio_strobe_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        req_valid, req_write, req_dev, req_csel;
    logic [2:0]  req_addr;
    logic [15:0] req_wdata;
    logic        busy, done;
    logic [15:0] rd_data;
    logic [2:0]  ata_addr;
    logic [1:0]  ata_cs_n;
    logic        ata_rd_n, ata_wr_n;
    logic [15:0] ata_dout;
    logic        ata_dout_en;
    logic [15:0] ata_din;

    always #2.5 clk = ~clk;

    pio_strobe_seq u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_dev(req_dev), .req_csel(req_csel), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .ata_addr(ata_addr), .ata_cs_n(ata_cs_n), .ata_rd_n(ata_rd_n),
        .ata_wr_n(ata_wr_n), .ata_dout(ata_dout), .ata_dout_en(ata_dout_en),
        .ata_din(ata_din)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit          started = 0;
    bit          m_busy, m_done, m_acc;
    int          k, S, P, T;
    logic        m_w, m_csel;
    logic [2:0]  m_addr;
    logic [15:0] m_wd, m_rd;
    logic [31:0] m_cfg;

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (rst) begin
            m_busy = 0; m_done = 0; m_acc = 0; k = 0; S = 0; P = 0; T = 0;
            m_w = 0; m_csel = 0; m_addr = 0; m_wd = 0; m_rd = 0; m_cfg = 0;
        end else begin
            m_done = 0;
            m_acc  = 0;
            if (m_busy) begin
                k++;
                if (k == S + P && !m_w) m_rd = ata_din;
                if (k == T) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (req_valid) begin
                int f, s, p, c;
                f = int'(m_cfg >> (req_dev ? 16 : 0));
                s = f & 7;
                p = (f >> 3) & 31;
                c = (f >> 8) & 63;
                S = (s < 1) ? 1 : s;
                P = (p < 1) ? 1 : p;
                T = (c > S + P + 1) ? c : S + P + 1;
                m_w = req_write; m_csel = req_csel; m_addr = req_addr; m_wd = req_wdata;
                m_busy = 1; k = 0; m_acc = 1;
            end
            if (cfg_we) m_cfg = cfg_wdata & 32'h3FFF_3FFF;
        end
    end

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        if (started) begin
            string t;
            logic  e_rd_n, e_wr_n, strb;
            t = rst ? "R1 " : "";
            strb   = m_busy && (k >= S) && (k < S + P);
            e_rd_n = !(strb && !m_w);
            e_wr_n = !(strb && m_w);
            chk({t, "R6 R9 busy"}, 32'(busy), 32'(m_busy));
            chk({t, "R6 done"}, 32'(done), 32'(m_done));
            chk({t, "R3 R4 R5 rd_n"}, 32'(ata_rd_n), 32'(e_rd_n));
            chk({t, "R3 R4 R5 wr_n"}, 32'(ata_wr_n), 32'(e_wr_n));
            chk({t, "R10 cs_n"}, 32'(ata_cs_n),
                m_busy ? (m_csel ? 32'h1 : 32'h2) : 32'h3);
            chk({t, "R10 addr"}, 32'(ata_addr), m_busy ? 32'(m_addr) : 32'h0);
            chk({t, "R8 dout_en"}, 32'(ata_dout_en), 32'(m_busy && m_w));
            chk({t, "R8 dout"}, 32'(ata_dout), (m_busy && m_w) ? 32'(m_wd) : 32'h0);
            chk({t, "R7 rd_data"}, 32'(rd_data), 32'(m_rd));
            chk({t, "R2 cfg_rdata"}, cfg_rdata, m_cfg);
            chk({t, "R11 strobe exclusion"}, 32'(ata_rd_n | ata_wr_n), 32'h1);
        end
    end

    // device data changes every clock so a wrong capture edge shows
    always @(negedge clk) ata_din <= ata_din + 16'h1357;

    // ---------------- stimulus ----------------
    function automatic logic [31:0] mk(int ms, int mp, int mc, int ss, int sp, int sc);
        return {2'b00, 6'(sc), 5'(sp), 3'(ss), 2'b00, 6'(mc), 5'(mp), 3'(ms)};
    endfunction

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic issue(input logic dev, input logic wr, input logic cs,
                         input logic [2:0] a, input logic [15:0] wd);
        @(negedge clk);
        req_dev = dev; req_write = wr; req_csel = cs; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        do @(negedge clk); while (!m_acc);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
    endtask

    task automatic run_all();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R2: reserved bits dropped
        write_cfg(32'hFFFF_FFFF);
        chk("R2 reserved bits read zero", cfg_rdata, 32'h3FFF_3FFF);
        // R3 master vs slave sets
        write_cfg(mk(2, 3, 10, 4, 6, 0));
        issue(1'b0, 1'b0, 1'b0, 3'd7, 16'h0);
        wait_idle();
        issue(1'b1, 1'b1, 1'b1, 3'd2, 16'hA5C3);
        wait_idle();
        // all-zero fields: one-clock floors
        write_cfg(32'h0);
        issue(1'b0, 1'b0, 1'b1, 3'd1, 16'h0);
        wait_idle();
        issue(1'b1, 1'b1, 1'b0, 3'd4, 16'h1234);
        wait_idle();
        // cycle shorter than setup+pulse+1
        write_cfg(mk(5, 8, 4, 7, 31, 63));
        issue(1'b0, 1'b1, 1'b0, 3'd3, 16'hBEEF);
        wait_idle();
        issue(1'b1, 1'b0, 1'b1, 3'd6, 16'h0);
        wait_idle();
        // R9 back-to-back requests held off by busy
        issue(1'b0, 1'b0, 1'b0, 3'd5, 16'h0);
        issue(1'b1, 1'b1, 1'b1, 3'd0, 16'h7E81);
        issue(1'b0, 1'b1, 1'b0, 3'd2, 16'h4242);
        wait_idle();
        // R3 register write during an access
        issue(1'b1, 1'b0, 1'b0, 3'd1, 16'h0);
        write_cfg(mk(1, 1, 0, 1, 2, 9));
        wait_idle();
        issue(1'b1, 1'b0, 1'b1, 3'd3, 16'h0);
        wait_idle();
        // R1 reset mid-access
        issue(1'b0, 1'b1, 1'b0, 3'd7, 16'hFFFF);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_wdata = 0; req_valid = 0; req_write = 0;
        req_dev = 0; req_csel = 0; req_addr = 0; req_wdata = 0; ata_din = 16'h0F0F;
        fork
            run_all();
            begin
                while (cyc < 100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog R6: actual hung expected completion");
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule